// File: doc/BRIEF.md
# Three-Level DMA Address Sequencer

This block produces the byte addresses for one DMA channel. A transfer has three levels. An array holds a number of consecutive bytes. A frame holds a number of arrays. A block holds a number of frames. The block keeps one active parameter set and a small table of stored sets. Each trigger starts a sub-transfer, which sends a run of source/destination address pairs, one byte per beat, over a valid/ready interface. The sync-mode bit of the option word sets the size of a sub-transfer: one array, or one whole frame.

Between arrays, each address moves by its own signed array stride. At the end of a frame, each address moves by its own signed frame stride. When the active set runs out, the link field selects a stored set, which is copied into the active set. If the link field holds the null value, the channel stops. A one-cycle completion pulse, tagged with the set's completion code, marks the end of each sub-transfer when the matching enable bit is set. A trigger that cannot start a sub-transfer sets a sticky error flag.

Software fills the sets through a plain write port. Each set has eight 32-bit words.

Top module: `dma3d_seq`

## Requirements
- R1: After reset, req_valid, done_valid and miss_err are low and the active set is empty, so a trigger starts no beats.
- R2: While req_valid is high and req_ready is low, the request stays asserted with unchanged addresses. A handshake moves one byte. Within an array, the source and destination addresses run up by 1 from the array start for ACNT beats.
- R3: With option bit 2 clear, one trigger moves one array. Between the arrays of a frame, the array strides are added to the array start: word 4 holds the source stride in [15:0] and the destination stride in [31:16], both 16-bit signed. After the last array of a frame, the frame strides are added to that array's start: word 5 uses the same layout. CCNT then drops by one, and the remaining array count is reloaded from word 3 [31:16].
- R4: With option bit 2 set, one trigger moves a whole frame of BCNT arrays, with the array strides added between arrays. The frame strides are then added to the frame's start address. The remaining array count restarts from BCNT and the word 3 reload value is ignored.
- R5: When option bit 21 is set, done_valid pulses for one cycle in the cycle after the last beat of each sub-transfer that does not end the set. done_code then carries option bits [13:8].
- R6: When option bit 20 is set, done_valid pulses in the same way after the sub-transfer that ends the set, which is the last frame.
- R7: A trigger that arrives while beats are pending, or while the active set is empty, starts nothing and sets miss_err. miss_err stays high until a cycle with err_clr high.
- R8: When the set ends and the link field (word 6 [15:0]) is not 0xFFFF, table entry link[SET_W-1:0] is copied into the active set, and the next trigger runs it.
- R9: When the set ends with link 0xFFFF, all counts become zero. Later triggers produce no beats and only set miss_err.
- R10: Write layout. cfg_tbl=0 writes the active set and cfg_tbl=1 writes table entry cfg_set. cfg_word selects the word: 0 is the source address, 1 the destination address, 2 is {BCNT, ACNT}, 3 is {BCNT reload, CCNT}, and 7 is the option word. ACNT, BCNT and CCNT are each at least 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Write strobe for a parameter word |
| cfg_tbl | input | 1 | 0 selects the active set, 1 selects a table entry |
| cfg_set | input | SET_W | Table entry index |
| cfg_word | input | 3 | Word index within the set |
| cfg_wdata | input | 32 | Write data |
| trig | input | 1 | Starts one sub-transfer |
| err_clr | input | 1 | Clears the missed-trigger flag |
| req_valid | output | 1 | Address pair valid |
| req_ready | input | 1 | Consumer accepts the address pair |
| req_src | output | 32 | Source byte address |
| req_dst | output | 32 | Destination byte address |
| done_valid | output | 1 | Completion pulse |
| done_code | output | TCC_W | Completion code of the finished sub-transfer |
| miss_err | output | 1 | Sticky missed-trigger flag |

## Verification
The checker watches four things on every cycle:
- request addresses stay stable under back-pressure;
- a completion pulse always follows a handshake;
- a trigger during beats raises the error flag;
- the error flag stays set until it is cleared.

Only the bench scenarios can show the address sequence itself: array and frame strides with both signs, the reload difference between the two sync modes, and which pulse goes with each sub-transfer. The same holds for the link copy, the stop at the null link, and random sets, with all results compared against a bench model of the counts.

// File: rtl/dma3d_seq.sv
module dma3d_seq #(
  parameter int LINK_SETS = 4,
  parameter int TCC_W = 6,
  localparam int SET_W = (LINK_SETS > 1) ? $clog2(LINK_SETS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic             cfg_tbl,
  input  logic [SET_W-1:0] cfg_set,
  input  logic [2:0]       cfg_word,
  input  logic [31:0]      cfg_wdata,
  input  logic             trig,
  input  logic             err_clr,
  output logic             req_valid,
  input  logic             req_ready,
  output logic [31:0]      req_src,
  output logic [31:0]      req_dst,
  output logic             done_valid,
  output logic [TCC_W-1:0] done_code,
  output logic             miss_err
);
  localparam int SYNC_BIT = 2;
  localparam int TCC_LSB = 8;
  localparam int FIN_BIT = 20;
  localparam int ITM_BIT = 21;
  localparam int WORDS = 8;
  localparam logic [15:0] NULL_LINK = 16'hFFFF;

  logic [31:0] tbl [LINK_SETS][WORDS];
  logic [31:0] act [WORDS];
  logic [31:0] a_src, a_dst, f_src, f_dst;
  logic [15:0] off, bleft, ccnt;

  function automatic logic [31:0] sx(input logic [15:0] v);
    return {{16{v[15]}}, v};
  endfunction

  logic [15:0] acnt, bcfg, brld, link;
  logic [SET_W-1:0] lsel;
  logic sync;
  assign acnt = act[2][15:0];
  assign bcfg = act[2][31:16];
  assign brld = act[3][31:16];
  assign link = act[6][15:0];
  assign lsel = link[SET_W-1:0];
  assign sync = act[7][SYNC_BIT];

  logic hs, arr_end, frm_end, set_end, sub_end, start;
  assign hs      = req_valid && req_ready;
  assign arr_end = hs && (off == acnt - 16'd1);
  assign frm_end = arr_end && (bleft == 16'd1);
  assign set_end = frm_end && (ccnt == 16'd1);
  assign sub_end = arr_end && (!sync || bleft == 16'd1);
  assign start   = trig && !req_valid && (ccnt != 16'd0);

  logic [31:0] nsrc, ndst;
  assign nsrc = (sync ? f_src : a_src) + sx(act[5][15:0]);
  assign ndst = (sync ? f_dst : a_dst) + sx(act[5][31:16]);

  assign req_src = a_src + {16'd0, off};
  assign req_dst = a_dst + {16'd0, off};

  always_ff @(posedge clk) begin
    if (cfg_we && cfg_tbl) tbl[cfg_set][cfg_word] <= cfg_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < WORDS; i++) act[i] <= '0;
      a_src <= '0; a_dst <= '0; f_src <= '0; f_dst <= '0;
      bleft <= '0; ccnt <= '0;
    end else if (cfg_we && !cfg_tbl) begin
      act[cfg_word] <= cfg_wdata;
      case (cfg_word)
        3'd0: begin a_src <= cfg_wdata; f_src <= cfg_wdata; end
        3'd1: begin a_dst <= cfg_wdata; f_dst <= cfg_wdata; end
        3'd2: bleft <= cfg_wdata[31:16];
        3'd3: ccnt <= cfg_wdata[15:0];
        default: ;
      endcase
    end else if (arr_end) begin
      if (set_end) begin
        if (link != NULL_LINK) begin
          act   <= tbl[lsel];
          a_src <= tbl[lsel][0]; f_src <= tbl[lsel][0];
          a_dst <= tbl[lsel][1]; f_dst <= tbl[lsel][1];
          bleft <= tbl[lsel][2][31:16];
          ccnt  <= tbl[lsel][3][15:0];
        end else begin
          ccnt <= '0; bleft <= '0;
          act[2] <= '0; act[3][15:0] <= '0;
        end
      end else if (frm_end) begin
        ccnt  <= ccnt - 16'd1;
        bleft <= sync ? bcfg : brld;
        a_src <= nsrc; f_src <= nsrc;
        a_dst <= ndst; f_dst <= ndst;
      end else begin
        bleft <= bleft - 16'd1;
        a_src <= a_src + sx(act[4][15:0]);
        a_dst <= a_dst + sx(act[4][31:16]);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_valid  <= 1'b0;
      off        <= '0;
      done_valid <= 1'b0;
      done_code  <= '0;
      miss_err   <= 1'b0;
    end else begin
      if (start) req_valid <= 1'b1;
      else if (sub_end) req_valid <= 1'b0;
      if (start || arr_end) off <= '0;
      else if (hs) off <= off + 16'd1;
      done_valid <= sub_end && (set_end ? act[7][FIN_BIT] : act[7][ITM_BIT]);
      if (sub_end) done_code <= act[7][TCC_LSB +: TCC_W];
      if (trig && (req_valid || ccnt == 16'd0)) miss_err <= 1'b1;
      else if (err_clr) miss_err <= 1'b0;
    end
  end
endmodule

// File: rtl/dma3d_seq_chk.sv
module dma3d_seq_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        trig,
  input logic        err_clr,
  input logic        req_valid,
  input logic        req_ready,
  input logic [31:0] req_src,
  input logic [31:0] req_dst,
  input logic        done_valid,
  input logic        miss_err
);
  a_r2_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_ready |=> req_valid && $stable(req_src) && $stable(req_dst));

  a_r5_done_after_beat: assert property (@(posedge clk) disable iff (!rst_n)
    done_valid |-> $past(req_valid && req_ready));

  a_r7_busy_trig_missed: assert property (@(posedge clk) disable iff (!rst_n)
    trig && req_valid |=> miss_err);

  a_r7_miss_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    miss_err && !err_clr |=> miss_err);
endmodule

bind dma3d_seq dma3d_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .trig(trig), .err_clr(err_clr),
  .req_valid(req_valid), .req_ready(req_ready), .req_src(req_src),
  .req_dst(req_dst), .done_valid(done_valid), .miss_err(miss_err)
);

// File: tb/dma3d_seq_tb.sv
module dma3d_seq_tb;
  localparam int TCC_W = 6;
  localparam int SET_W = 2;

  logic clk = 0, rst_n = 0;
  logic cfg_we = 0, cfg_tbl = 0;
  logic [SET_W-1:0] cfg_set = 0;
  logic [2:0] cfg_word = 0;
  logic [31:0] cfg_wdata = 0;
  logic trig = 0, err_clr = 0, req_ready = 0;
  logic req_valid, done_valid, miss_err;
  logic [31:0] req_src, req_dst;
  logic [TCC_W-1:0] done_code;

  dma3d_seq #(.LINK_SETS(4), .TCC_W(TCC_W)) u_dut (.*);

  always #10 clk = ~clk;

  int checks = 0, fails = 0;
  bit hold = 0;
  bit [31:0] got_s[$], got_d[$], exp_s[$], exp_d[$];
  int done_cnt = 0;
  logic [TCC_W-1:0] last_code;
  bit prev_hs = 0;

  task automatic check(input bit ok, input string req, input string what);
    checks++;
    if (!ok) begin fails++; $display("FAIL %s: %s", req, what); end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    #1;
    req_ready = !hold && ($urandom_range(3) != 0);
  end

  always @(negedge clk) begin
    if (done_valid) begin
      done_cnt++; last_code = done_code;
      check(prev_hs, "R5", $sformatf("done pulse not right after a beat: actual 0 expected 1"));
    end
    prev_hs = req_valid && req_ready;
    if (req_valid && req_ready) begin got_s.push_back(req_src); got_d.push_back(req_dst); end
  end

  initial begin
    #(20 * 150000);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  bit [31:0] tw [4][8];
  bit [31:0] wbuf [8];
  bit [31:0] ms_a, md_a, ms_f, md_f, m_opt;
  int m_ac, m_bl, m_cc, m_bcfg, m_brld, m_sbi, m_dbi, m_sci, m_dci, m_link;
  bit e_done;
  logic [TCC_W-1:0] e_code;

  function automatic int s16(input bit [15:0] v);
    return int'(signed'(v));
  endfunction

  function automatic void load_model(input bit [31:0] w [8]);
    ms_a = w[0]; ms_f = w[0]; md_a = w[1]; md_f = w[1];
    m_ac = w[2][15:0]; m_bcfg = w[2][31:16]; m_bl = m_bcfg;
    m_cc = w[3][15:0]; m_brld = w[3][31:16];
    m_sbi = s16(w[4][15:0]); m_dbi = s16(w[4][31:16]);
    m_sci = s16(w[5][15:0]); m_dci = s16(w[5][31:16]);
    m_link = w[6][15:0]; m_opt = w[7];
  endfunction

  function automatic void mk(input bit [31:0] s, input bit [31:0] d, input int ac, input int bc,
                             input int cc, input int brl, input int sbi, input int dbi,
                             input int sci, input int dci, input int lnk, input bit sy,
                             input int tcc, input bit fin, input bit itm);
    wbuf[0] = s; wbuf[1] = d;
    wbuf[2] = {bc[15:0], ac[15:0]};
    wbuf[3] = {brl[15:0], cc[15:0]};
    wbuf[4] = {dbi[15:0], sbi[15:0]};
    wbuf[5] = {dci[15:0], sci[15:0]};
    wbuf[6] = {16'd0, lnk[15:0]};
    wbuf[7] = 32'(itm) << 21 | 32'(fin) << 20 | 32'(tcc[5:0]) << 8 | 32'(sy) << 2;
  endfunction

  task automatic prog(input bit tbl, input int set);
    for (int i = 0; i < 8; i++) begin
      @(posedge clk); #1;
      cfg_we = 1; cfg_tbl = tbl; cfg_set = set[SET_W-1:0]; cfg_word = i[2:0]; cfg_wdata = wbuf[i];
    end
    @(posedge clk); #1 cfg_we = 0;
    if (tbl) tw[set] = wbuf; else load_model(wbuf);
  endtask

  function automatic void gen_expect();
    bit sy, fin_sub, last;
    if (m_cc == 0) return;
    sy = m_opt[2];
    fin_sub = 0; last = 0;
    while (!fin_sub) begin
      for (int b = 0; b < m_ac; b++) begin
        exp_s.push_back(ms_a + 32'(b)); exp_d.push_back(md_a + 32'(b));
      end
      if (m_bl > 1) begin
        m_bl--; ms_a += 32'(m_sbi); md_a += 32'(m_dbi);
        if (!sy) fin_sub = 1;
      end else begin
        fin_sub = 1;
        last = (m_cc == 1);
        m_cc--;
        if (sy) begin ms_f += 32'(m_sci); md_f += 32'(m_dci); ms_a = ms_f; md_a = md_f; end
        else begin ms_a += 32'(m_sci); md_a += 32'(m_dci); ms_f = ms_a; md_f = md_a; end
        m_bl = sy ? m_bcfg : m_brld;
      end
    end
    e_done = last ? m_opt[20] : m_opt[21];
    e_code = m_opt[8 +: TCC_W];
    if (last) begin
      if (m_link != 16'hFFFF) load_model(tw[m_link % 4]);
      else begin m_ac = 0; m_bl = 0; m_cc = 0; end
    end
  endfunction

  task automatic do_trig(input string tag, input bit inject);
    bit exp_miss; int dn0; int t; bit ok;
    exp_s.delete(); exp_d.delete(); got_s.delete(); got_d.delete();
    exp_miss = (m_cc == 0);
    e_done = 0;
    gen_expect();
    dn0 = done_cnt;
    if (inject) hold = 1;
    @(posedge clk); #1 trig = 1;
    @(posedge clk); #1 trig = 0;
    if (inject) begin
      repeat (2) @(posedge clk);
      #1 trig = 1;
      @(posedge clk); #1 trig = 0;
      @(posedge clk); #5;
      check(miss_err == 1, "R7", $sformatf("%s trig while busy: miss actual %0d expected 1", tag, miss_err));
      check(got_s.size() == 0, "R2", $sformatf("%s beats under back-pressure actual %0d expected 0", tag, got_s.size()));
      hold = 0;
    end
    t = 0;
    while (got_s.size() < exp_s.size() && t < 5000) begin @(posedge clk); t++; end
    repeat (4) @(posedge clk);
    #5;
    ok = (got_s.size() == exp_s.size());
    if (ok) foreach (exp_s[i]) if (got_s[i] != exp_s[i] || got_d[i] != exp_d[i]) ok = 0;
    check(ok, tag, $sformatf("beats actual n=%0d first=%h expected n=%0d first=%h", got_s.size(),
          got_s.size() ? got_s[0] : 0, exp_s.size(), exp_s.size() ? exp_s[0] : 0));
    if (exp_miss)
      check(miss_err == 1, "R9", $sformatf("%s empty trigger: miss actual %0d expected 1", tag, miss_err));
    else begin
      check(done_cnt - dn0 == int'(e_done), e_done ? "R5 R6" : "R5",
            $sformatf("%s done pulses actual %0d expected %0d", tag, done_cnt - dn0, e_done));
      if (e_done)
        check(last_code == e_code, "R5", $sformatf("%s code actual %0d expected %0d", tag, last_code, e_code));
    end
  endtask

  task automatic clear_err();
    @(posedge clk); #1 err_clr = 1;
    @(posedge clk); #1 err_clr = 0;
    #5;
    check(miss_err == 0, "R7", $sformatf("err_clr: miss actual %0d expected 0", miss_err));
  endtask

  initial begin
    void'($urandom(32'd20240607));
    m_ac = 0; m_bl = 0; m_cc = 0; m_link = 16'hFFFF; m_opt = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    check(req_valid == 0, "R1", $sformatf("req_valid actual %0d expected 0", req_valid));
    check(done_valid == 0, "R1", $sformatf("done_valid actual %0d expected 0", done_valid));
    check(miss_err == 0, "R1", $sformatf("miss_err actual %0d expected 0", miss_err));
    do_trig("R1 empty", 0);
    clear_err();

    mk(32'h0000_2000, 32'h0000_9000, 2, 3, 2, 7, 4, -8, 100, -300, 16'hFFFF, 1, 9, 1, 0);
    prog(1, 1);
    mk(32'h0000_1000, 32'h0000_5000, 3, 2, 2, 3, 10, -20, 50, 64, 1, 0, 5, 1, 1);
    prog(0, 0);
    do_trig("R3 R10 A-sync first array", 1);
    clear_err();
    for (int k = 0; k < 4; k++) do_trig("R3 A-sync", 0);
    do_trig("R8 R4 linked AB-sync", 0);
    do_trig("R4 R6 AB-sync last", 0);
    do_trig("R9 null link", 0);
    clear_err();

    for (int it = 0; it < 8; it++) begin
      int guard;
      mk($urandom, $urandom, $urandom_range(4, 1), $urandom_range(3, 1), $urandom_range(3, 1),
         $urandom_range(3, 1), $urandom_range(100) - 50, $urandom_range(100) - 50,
         $urandom_range(600) - 300, $urandom_range(600) - 300, 16'hFFFF,
         $urandom_range(1), $urandom_range(63), $urandom_range(1), $urandom_range(1));
      prog(0, 0);
      guard = 0;
      while (m_cc != 0 && guard < 20) begin do_trig("R2 R3 R4 random", 0); guard++; end
      do_trig("R9 random end", 0);
      clear_err();
    end
    finish_run();
  end
endmodule